// File: doc/BRIEF.md
# CPU Flag Register Controller

This block keeps the four status flags of a small 4-bit processor core: zero, carry, interrupt enable and extension mode. In every cycle the core presents an operation-class code together with the ALU's zero and carry/borrow results. The block then decides, class by class, which flags take the new values and which keep their old ones. Arithmetic and shift classes update both zero and carry. Logic, index-register add and stack-pointer step classes update zero only. Loads, jumps and idle cycles leave both untouched.

The same register handles interrupt acceptance and the extension prefix. A maskable request is taken only while interrupts are enabled. A non-maskable request and a software trap are always taken. Taking a hardware request, maskable or not, turns interrupts off. A load of the extension register marks the next instruction as extended, and that mark clears once the next instruction completes.

Software controls the flags through a small set of explicit classes: replace all four, clear selected bits, set selected bits, invert selected bits, and reload from a saved copy when popping the flags or returning from an interrupt. Software reads the flags directly from the output.

Top module: `flag_ctrl`

## Requirements
- R1: After reset the flag output is 4'b0000, so interrupts are disabled, and a maskable request raised in that state is not accepted.
- R2: Flag layout: bit 3 is extension mode, bit 2 is interrupt enable, bit 1 is carry, bit 0 is zero. Class codes: 0 idle/load/jump, 1 arithmetic, 2 shift/rotate, 3 logic, 4 index add or stack-pointer step, 5 write all flags, 6 AND, 7 OR, 8 XOR, 9 restore. Codes 10 to 15 act as idle.
- R3: In classes 1 and 2, on the next edge zero takes alu_zero and carry takes alu_carry.
- R4: In classes 3 and 4, zero takes alu_zero and carry keeps its value.
- R5: In class 0 and in codes 10 to 15, zero and carry keep their values.
- R6: Class 5 loads wr_val into all four flags. Class 6 clears the flags whose wr_val bit is 1, class 7 sets them, and class 8 inverts them.
- R7: Class 9 loads restore_val into all four flags.
- R8: int_accept is high in the same cycle when nmi or swi is high, or when hw_irq is high while the interrupt-enable flag is 1. It is low otherwise.
- R9: An accepted hw_irq or any nmi clears interrupt enable on the next edge. A swi leaves interrupt enable unchanged.
- R10: ext_load sets extension mode on the next edge. instr_done without ext_load clears it.
- R11: In classes 5 to 9 the explicit value wins over every automatic update in the same cycle, including the interrupt and extension updates. int_accept is still decided from the current flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_cls | input | 4 | Operation-class code |
| alu_zero | input | 1 | ALU result was zero |
| alu_carry | input | 1 | ALU carry out or borrow |
| hw_irq | input | 1 | Maskable hardware interrupt request |
| nmi | input | 1 | Non-maskable interrupt request |
| swi | input | 1 | Software interrupt |
| ext_load | input | 1 | Extension register is being loaded |
| instr_done | input | 1 | An instruction completes this cycle |
| wr_val | input | 4 | Accumulator or immediate for explicit flag classes |
| restore_val | input | 4 | Saved flags for pop and interrupt return |
| flags | output | 4 | Current flag register |
| int_accept | output | 1 | An interrupt is taken this cycle |

## Verification
The bench builds the block with its default parameters: a four-bit class code and a reset value of zero. With these, every class code, including the six unused ones, can be crossed with all sixteen starting flag states, all sixteen write values and all four ALU result pairs. A second sweep crosses all thirty-two combinations of the interrupt and extension strobes with every starting state, under the idle, arithmetic, logic, write and restore classes. That sweep reaches the priority cases in which an explicit write meets an interrupt or an extension update in the same cycle.

// File: rtl/flag_pkg.sv
package flag_pkg;

  localparam int FLAG_W = 4;
  localparam int OPC_W  = 4;

  localparam int FB_Z = 0;
  localparam int FB_C = 1;
  localparam int FB_I = 2;
  localparam int FB_E = 3;

  typedef enum logic [OPC_W-1:0] {
    CLS_IDLE    = 4'd0,
    CLS_ARITH   = 4'd1,
    CLS_SHIFT   = 4'd2,
    CLS_LOGIC   = 4'd3,
    CLS_PTRADD  = 4'd4,
    CLS_FSET    = 4'd5,
    CLS_FAND    = 4'd6,
    CLS_FOR     = 4'd7,
    CLS_FXOR    = 4'd8,
    CLS_RESTORE = 4'd9
  } op_cls_e;

  // {update carry, update zero} for an operation class
  function automatic logic [1:0] zc_mask(input logic [OPC_W-1:0] cls);
    case (cls)
      CLS_ARITH, CLS_SHIFT:  zc_mask = 2'b11;
      CLS_LOGIC, CLS_PTRADD: zc_mask = 2'b01;
      default:               zc_mask = 2'b00;
    endcase
  endfunction

  function automatic logic is_explicit(input logic [OPC_W-1:0] cls);
    is_explicit = (cls >= CLS_FSET) && (cls <= CLS_RESTORE);
  endfunction

  // Result of an explicit flag operation applied to the current register
  function automatic logic [FLAG_W-1:0] explicit_val(
      input logic [OPC_W-1:0]  cls,
      input logic [FLAG_W-1:0] cur,
      input logic [FLAG_W-1:0] opnd,
      input logic [FLAG_W-1:0] saved);
    case (cls)
      CLS_FSET: explicit_val = opnd;
      CLS_FAND: explicit_val = cur & ~opnd;
      CLS_FOR:  explicit_val = cur | opnd;
      CLS_FXOR: explicit_val = cur ^ opnd;
      default:  explicit_val = saved;
    endcase
  endfunction

endpackage

// File: rtl/flag_zc_upd.sv
module flag_zc_upd
  import flag_pkg::*;
(
  input  logic [OPC_W-1:0] cls,
  input  logic             alu_zero,
  input  logic             alu_carry,
  input  logic             cur_z,
  input  logic             cur_c,
  output logic             nxt_z,
  output logic             nxt_c
);
  logic [1:0] mask;

  always_comb begin
    mask  = zc_mask(cls);
    nxt_z = mask[0] ? alu_zero  : cur_z;
    nxt_c = mask[1] ? alu_carry : cur_c;
  end
endmodule

// File: rtl/flag_ie_ctrl.sv
module flag_ie_ctrl (
  input  logic cur_i,
  input  logic cur_e,
  input  logic hw_irq,
  input  logic nmi,
  input  logic swi,
  input  logic ext_load,
  input  logic instr_done,
  output logic nxt_i,
  output logic nxt_e,
  output logic hw_taken,
  output logic int_accept
);
  always_comb begin
    hw_taken   = hw_irq & cur_i;
    int_accept = hw_taken | nmi | swi;
    // hardware acceptance disables further maskable requests; swi does not
    nxt_i      = (hw_taken | nmi) ? 1'b0 : cur_i;
    if (ext_load)        nxt_e = 1'b1;
    else if (instr_done) nxt_e = 1'b0;
    else                 nxt_e = cur_e;
  end
endmodule

// File: rtl/flag_explicit.sv
module flag_explicit
  import flag_pkg::*;
(
  input  logic [OPC_W-1:0]  cls,
  input  logic [FLAG_W-1:0] cur,
  input  logic [FLAG_W-1:0] wr_val,
  input  logic [FLAG_W-1:0] restore_val,
  output logic              exp_en,
  output logic [FLAG_W-1:0] exp_flags
);
  always_comb begin
    exp_en    = is_explicit(cls);
    exp_flags = explicit_val(cls, cur, wr_val, restore_val);
  end
endmodule

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
#(
  parameter logic [FLAG_W-1:0] RST_FLAGS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  op_cls,
  input  logic              alu_zero,
  input  logic              alu_carry,
  input  logic              hw_irq,
  input  logic              nmi,
  input  logic              swi,
  input  logic              ext_load,
  input  logic              instr_done,
  input  logic [FLAG_W-1:0] wr_val,
  input  logic [FLAG_W-1:0] restore_val,
  output logic [FLAG_W-1:0] flags,
  output logic              int_accept
);
  logic [FLAG_W-1:0] flag_q;
  logic [FLAG_W-1:0] auto_flags;
  logic [FLAG_W-1:0] exp_flags;
  logic [FLAG_W-1:0] nxt_flags;
  logic              explicit_en;
  logic              hw_taken;

  flag_zc_upd u_zc (
    .cls       (op_cls),
    .alu_zero  (alu_zero),
    .alu_carry (alu_carry),
    .cur_z     (flag_q[FB_Z]),
    .cur_c     (flag_q[FB_C]),
    .nxt_z     (auto_flags[FB_Z]),
    .nxt_c     (auto_flags[FB_C])
  );

  flag_ie_ctrl u_ie (
    .cur_i      (flag_q[FB_I]),
    .cur_e      (flag_q[FB_E]),
    .hw_irq     (hw_irq),
    .nmi        (nmi),
    .swi        (swi),
    .ext_load   (ext_load),
    .instr_done (instr_done),
    .nxt_i      (auto_flags[FB_I]),
    .nxt_e      (auto_flags[FB_E]),
    .hw_taken   (hw_taken),
    .int_accept (int_accept)
  );

  flag_explicit u_exp (
    .cls         (op_cls),
    .cur         (flag_q),
    .wr_val      (wr_val),
    .restore_val (restore_val),
    .exp_en      (explicit_en),
    .exp_flags   (exp_flags)
  );

  genvar b;
  generate
    for (b = 0; b < FLAG_W; b++) begin : g_bit
      assign nxt_flags[b] = explicit_en ? exp_flags[b] : auto_flags[b];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[b] <= RST_FLAGS[b];
        else        flag_q[b] <= nxt_flags[b];
      end
    end
  endgenerate

  assign flags = flag_q;
endmodule

// File: rtl/flag_ctrl_chk.sv
module flag_ctrl_chk
  import flag_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [OPC_W-1:0]  op_cls,
  input logic              alu_zero,
  input logic              alu_carry,
  input logic              hw_irq,
  input logic              nmi,
  input logic              swi,
  input logic              ext_load,
  input logic [FLAG_W-1:0] wr_val,
  input logic [FLAG_W-1:0] restore_val,
  input logic [FLAG_W-1:0] flags,
  input logic              int_accept,
  input logic              hw_taken
);
  logic expl;
  assign expl = (op_cls >= 4'd5) && (op_cls <= 4'd9);

  p_arith_zc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cls == 4'd1 || op_cls == 4'd2) |=> flags[1:0] == {$past(alu_carry), $past(alu_zero)});

  p_keep_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cls == 4'd3 || op_cls == 4'd4) |=> (flags[1] == $past(flags[1])) && (flags[0] == $past(alu_zero)));

  p_hold_zc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cls == 4'd0 || op_cls >= 4'd10) |=> $stable(flags[1:0]));

  p_or_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cls == 4'd7) |=> flags == ($past(flags) | $past(wr_val)));

  p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cls == 4'd9) |=> flags == $past(restore_val));

  p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[2] && !nmi && !swi) |-> !int_accept);

  p_always_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi || swi || hw_taken) |-> int_accept);

  p_clear_ie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_taken || nmi) && !expl) |=> !flags[2]);

  p_swi_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (swi && !hw_irq && !nmi && !expl) |=> $stable(flags[2]));

  p_ext_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_load && !expl) |=> flags[3]);
endmodule

bind flag_ctrl flag_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_cls      (op_cls),
  .alu_zero    (alu_zero),
  .alu_carry   (alu_carry),
  .hw_irq      (hw_irq),
  .nmi         (nmi),
  .swi         (swi),
  .ext_load    (ext_load),
  .wr_val      (wr_val),
  .restore_val (restore_val),
  .flags       (flags),
  .int_accept  (int_accept),
  .hw_taken    (hw_taken)
);

// File: tb/flag_ctrl_test.sv
`timescale 1ns/1ps
module flag_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_cls = '0;
  logic       alu_zero = 1'b0, alu_carry = 1'b0;
  logic       hw_irq = 1'b0, nmi = 1'b0, swi = 1'b0;
  logic       ext_load = 1'b0, instr_done = 1'b0;
  logic [3:0] wr_val = '0, restore_val = '0;
  logic [3:0] flags;
  logic       int_accept;

  int checks = 0;
  int errors = 0;
  logic [3:0] model = 4'b0000;

  always #5 clk = ~clk;

  flag_ctrl uut (
    .clk(clk), .rst_n(rst_n), .op_cls(op_cls), .alu_zero(alu_zero),
    .alu_carry(alu_carry), .hw_irq(hw_irq), .nmi(nmi), .swi(swi),
    .ext_load(ext_load), .instr_done(instr_done), .wr_val(wr_val),
    .restore_val(restore_val), .flags(flags), .int_accept(int_accept)
  );

  // Independent model: bit order {E, I, C, Z}
  function automatic logic [3:0] predict(input logic [3:0] cur, input logic [3:0] op,
      input logic az, input logic ac, input logic [4:0] s, input logic [3:0] v,
      input logic [3:0] r);
    logic z, c, i, e;
    z = cur[0]; c = cur[1]; i = cur[2]; e = cur[3];
    if (op == 1 || op == 2) begin z = az; c = ac; end
    else if (op == 3 || op == 4) z = az;
    if ((s[0] && cur[2]) || s[1]) i = 1'b0;
    if (s[3]) e = 1'b1; else if (s[4]) e = 1'b0;
    case (op)
      4'd5: predict = v;
      4'd6: predict = cur & ~v;
      4'd7: predict = cur | v;
      4'd8: predict = cur ^ v;
      4'd9: predict = r;
      default: predict = {e, i, c, z};
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    if (op == 1 || op == 2) return "R3";
    if (op == 3 || op == 4) return "R4";
    if (op >= 5 && op <= 8) return "R6";
    if (op == 9) return "R7";
    return "R5";
  endfunction

  // s = {instr_done, ext_load, swi, nmi, hw_irq}; called at a falling edge
  task automatic step(input logic [3:0] op, input logic az, input logic ac,
      input logic [4:0] s, input logic [3:0] v, input logic [3:0] r, input string tag);
    logic [3:0] exp_f;
    logic       exp_a;
    op_cls = op; alu_zero = az; alu_carry = ac;
    hw_irq = s[0]; nmi = s[1]; swi = s[2]; ext_load = s[3]; instr_done = s[4];
    wr_val = v; restore_val = r;
    exp_a = (s[0] && model[2]) || s[1] || s[2];
    exp_f = predict(model, op, az, ac, s, v, r);
    #4;
    checks++;
    if (int_accept !== exp_a) begin
      errors++;
      $display("FAIL R8 int_accept op=%0d s=%b got %b exp %b", op, s, int_accept, exp_a);
    end
    @(negedge clk);
    checks++;
    if (flags !== exp_f) begin
      errors++;
      $display("FAIL %s flags op=%0d s=%b got %b exp %b", tag, op, s, flags, exp_f);
    end
    model = exp_f;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    hw_irq = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (flags !== 4'b0000 || int_accept !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset flags=%b acc=%b exp 0000/0", flags, int_accept);
    end
    hw_irq = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (flags !== 4'b0000) begin
      errors++;
      $display("FAIL R1 after release flags=%b exp 0000", flags);
    end
    model = 4'b0000;

    // R2: bit positions through their own effects
    step(4'd5, 0, 0, 5'b00000, 4'b1000, 4'd0, "R2");
    step(4'd0, 0, 0, 5'b10000, 4'd0, 4'd0, "R2");
    step(4'd5, 0, 0, 5'b00000, 4'b0100, 4'd0, "R2");
    step(4'd0, 0, 0, 5'b00001, 4'd0, 4'd0, "R2");
    step(4'd1, 0, 1, 5'b00000, 4'd0, 4'd0, "R2");
    step(4'd1, 1, 0, 5'b00000, 4'd0, 4'd0, "R2");

    // Sweep 1: every class x start state x operand x ALU pair
    for (int op = 0; op < 16; op++)
      for (int st = 0; st < 16; st++)
        for (int v = 0; v < 16; v++)
          for (int a = 0; a < 4; a++) begin
            step(4'd5, 0, 0, 5'b00000, 4'(st), 4'd0, "R6");
            step(4'(op), a[0], a[1], 5'b00000, 4'(v), 4'(~v), tag_of(4'(op)));
          end

    // Sweep 2: all strobe combinations (R8 R9 R10, explicit priority R11)
    for (int s = 0; s < 32; s++)
      for (int st = 0; st < 16; st++)
        for (int k = 0; k < 5; k++) begin
          logic [3:0] op;
          op = (k == 0) ? 4'd0 : (k == 1) ? 4'd1 : (k == 2) ? 4'd3 : (k == 3) ? 4'd5 : 4'd9;
          step(4'd5, 0, 0, 5'b00000, 4'(st), 4'd0, "R6");
          step(op, s[0], s[1], 5'(s), 4'(st + s), 4'(s), (op >= 5) ? "R11" : "R9 R10");
        end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule